// File: doc/BRIEF.md
# Direct-Mapped Instruction Translation Buffer

This block caches virtual-to-physical page translations for the instruction fetch path. It holds 64 entries, one per value of the virtual index, over 8 KB pages. The fetch side presents a 32-bit virtual address with a lookup enable. On the following clock the block returns a hit flag, the 19-bit physical page number, the user and supervisor execute permissions and a cache-inhibit attribute, all taken from the indexed entry.

Software fills and inspects entries through a special-purpose register port. The port has a chip select, a write strobe, a 16-bit address, write data and registered read data. Each entry appears as two words: a match word that carries the valid flag and the virtual tag, and a translate word that carries the physical page and its attributes. The two words sit in two separate address windows.

Top module: `itlb_dm`

## Requirements
- R1: After reset every entry is invalid and all its fields are zero. `hit_o`, `ppn_o`, `uxe_o`, `sxe_o`, `ci_o` and `spr_rdata_o` are zero, and any lookup misses until software writes a match word.
- R2: A lookup uses virtual address bits 18:13 as the entry index and bits 31:13 as the page number. Bits 12:0 are the page offset and have no effect. The results appear one clock after the edge on which `lkp_en_i` is high.
- R3: `hit_o` is 1 only when the indexed entry is valid and its stored 13-bit tag equals virtual address bits 31:19. A clear valid bit or a differing tag gives `hit_o` = 0.
- R4: `ppn_o`, `uxe_o`, `sxe_o` and `ci_o` show the translate fields of the indexed entry, whether or not the lookup hits.
- R5: On an edge where `lkp_en_i` is low, every lookup output keeps its value.
- R6: Match words sit at SPR addresses 0x1200 + i, for entry i from 0 to 63. Writing one sets valid from bit 0 and the tag from bits 31:19. Reading one returns the same fields in the same places, with bits 18:1 read as zero.
- R7: Translate words sit at SPR addresses 0x1300 + i. The physical page number is in bits 31:13, user execute in bit 7, supervisor execute in bit 6 and cache inhibit in bit 1. Reading one returns these fields, with all other bits read as zero.
- R8: A write happens only on an edge where `spr_cs_i` and `spr_we_i` are both high. A write to an address outside the two windows changes no entry. A read of such an address returns zero.
- R9: SPR read data appears one clock after the edge where `spr_cs_i` is high and `spr_we_i` is low. On any other edge `spr_rdata_o` keeps its value.
- R10: A lookup and an SPR write on the same edge are both carried out, and the lookup returns the entry contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_en_i | input | 1 | Lookup request |
| lkp_vaddr_i | input | 32 | Virtual fetch address |
| hit_o | output | 1 | Translation hit |
| ppn_o | output | 19 | Physical page number |
| uxe_o | output | 1 | User execute enable |
| sxe_o | output | 1 | Supervisor execute enable |
| ci_o | output | 1 | Cache inhibit attribute |
| spr_cs_i | input | 1 | SPR chip select |
| spr_we_i | input | 1 | SPR write strobe |
| spr_addr_i | input | 16 | SPR address |
| spr_wdata_i | input | 32 | SPR write data |
| spr_rdata_o | output | 32 | SPR read data, registered |

## Verification
The assertions assume that `lkp_en_i`, `spr_cs_i` and `spr_we_i` are never X or Z after reset, and that the SPR address is stable at each sampling edge. The stability checks depend on this, because they compare against the previous cycle. The bench changes every input only on the falling clock edge and drives all of them from time zero. Its random traffic mixes addresses inside the two windows with addresses just outside them, so the checks on zero readback are exercised.

// File: rtl/itlb_pkg.sv
`timescale 1ns/1ps
package itlb_pkg;
  parameter int VA_W   = 32;
  parameter int PAGE_W = 13;
  parameter int IDX_W  = 6;
  parameter int SPR_AW = 16;

  localparam int DATA_W  = VA_W;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int VPN_W   = VA_W - PAGE_W;
  localparam int TAG_W   = VPN_W - IDX_W;
  localparam int PPN_W   = VPN_W;
  localparam int TAG_LSB = PAGE_W + IDX_W;

  localparam int VALID_POS = 0;
  localparam int CI_POS    = 1;
  localparam int SXE_POS   = 6;
  localparam int UXE_POS   = 7;

  localparam logic [SPR_AW-1:0] MATCH_BASE = 16'h1200;
  localparam logic [SPR_AW-1:0] XLATE_BASE = 16'h1300;

  typedef struct packed {
    logic             valid;
    logic [TAG_W-1:0] tag;
    logic [PPN_W-1:0] ppn;
    logic             uxe;
    logic             sxe;
    logic             ci;
  } itlb_entry_t;

  typedef enum logic [1:0] {
    WIN_NONE  = 2'd0,
    WIN_MATCH = 2'd1,
    WIN_XLATE = 2'd2
  } spr_win_e;
endpackage

// File: rtl/itlb_spr_decode.sv
`timescale 1ns/1ps
module itlb_spr_decode
  import itlb_pkg::*;
#(
  parameter logic [SPR_AW-1:0] MBASE = MATCH_BASE,
  parameter logic [SPR_AW-1:0] XBASE = XLATE_BASE
) (
  input  logic [SPR_AW-1:0] addr_i,
  output spr_win_e          win_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic hit_m, hit_x;

  assign hit_m = (addr_i[SPR_AW-1:IDX_W] == MBASE[SPR_AW-1:IDX_W]);
  assign hit_x = (addr_i[SPR_AW-1:IDX_W] == XBASE[SPR_AW-1:IDX_W]);
  assign idx_o = addr_i[IDX_W-1:0];

  always_comb begin
    if (hit_m)      win_o = WIN_MATCH;
    else if (hit_x) win_o = WIN_XLATE;
    else            win_o = WIN_NONE;
  end
endmodule

// File: rtl/itlb_entry_array.sv
`timescale 1ns/1ps
module itlb_entry_array
  import itlb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_match_i,
  input  logic              we_xlate_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_a_i,
  output itlb_entry_t       rent_a_o,
  input  logic [IDX_W-1:0]  ridx_b_i,
  output itlb_entry_t       rent_b_o
);
  itlb_entry_t ent [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    itlb_entry_t e_q;
    logic        sel;

    assign sel = (widx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        e_q <= '0;
      end else begin
        if (we_match_i && sel) begin
          e_q.valid <= wdata_i[VALID_POS];
          e_q.tag   <= wdata_i[DATA_W-1 -: TAG_W];
        end
        if (we_xlate_i && sel) begin
          e_q.ppn <= wdata_i[DATA_W-1 -: PPN_W];
          e_q.uxe <= wdata_i[UXE_POS];
          e_q.sxe <= wdata_i[SXE_POS];
          e_q.ci  <= wdata_i[CI_POS];
        end
      end
    end

    assign ent[g] = e_q;
  end

  assign rent_a_o = ent[ridx_a_i];
  assign rent_b_o = ent[ridx_b_i];
endmodule

// File: rtl/itlb_lookup_stage.sv
`timescale 1ns/1ps
module itlb_lookup_stage
  import itlb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [VA_W-1:0]   vaddr_i,
  input  itlb_entry_t       rent_i,
  output logic              hit_o,
  output logic [PPN_W-1:0]  ppn_o,
  output logic              uxe_o,
  output logic              sxe_o,
  output logic              ci_o
);
  itlb_entry_t      ent_q;
  logic [TAG_W-1:0] tag_q;

  // capture entry before any same-edge write lands
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_q <= '0;
      tag_q <= '0;
    end else if (en_i) begin
      ent_q <= rent_i;
      tag_q <= vaddr_i[VA_W-1:TAG_LSB];
    end
  end

  assign hit_o = ent_q.valid && (ent_q.tag == tag_q);
  assign ppn_o = ent_q.ppn;
  assign uxe_o = ent_q.uxe;
  assign sxe_o = ent_q.sxe;
  assign ci_o  = ent_q.ci;
endmodule

// File: rtl/itlb_spr_read.sv
`timescale 1ns/1ps
module itlb_spr_read
  import itlb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  spr_win_e          win_i,
  input  itlb_entry_t       rent_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] word_d, rdata_q;

  always_comb begin
    word_d = '0;
    unique case (win_i)
      WIN_MATCH: begin
        word_d[VALID_POS]           = rent_i.valid;
        word_d[DATA_W-1 -: TAG_W]   = rent_i.tag;
      end
      WIN_XLATE: begin
        word_d[DATA_W-1 -: PPN_W]   = rent_i.ppn;
        word_d[UXE_POS]             = rent_i.uxe;
        word_d[SXE_POS]             = rent_i.sxe;
        word_d[CI_POS]              = rent_i.ci;
      end
      default: word_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= word_d;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/itlb_dm.sv
`timescale 1ns/1ps
module itlb_dm
  import itlb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lkp_en_i,
  input  logic [VA_W-1:0]   lkp_vaddr_i,
  output logic              hit_o,
  output logic [PPN_W-1:0]  ppn_o,
  output logic              uxe_o,
  output logic              sxe_o,
  output logic              ci_o,
  input  logic              spr_cs_i,
  input  logic              spr_we_i,
  input  logic [SPR_AW-1:0] spr_addr_i,
  input  logic [DATA_W-1:0] spr_wdata_i,
  output logic [DATA_W-1:0] spr_rdata_o
);
  spr_win_e         win;
  logic [IDX_W-1:0] spr_idx;
  logic [IDX_W-1:0] lkp_idx;
  itlb_entry_t      lkp_ent, spr_ent;
  logic             we_m, we_x, rd;

  assign lkp_idx = lkp_vaddr_i[PAGE_W +: IDX_W];
  assign we_m    = spr_cs_i && spr_we_i && (win == WIN_MATCH);
  assign we_x    = spr_cs_i && spr_we_i && (win == WIN_XLATE);
  assign rd      = spr_cs_i && !spr_we_i;

  itlb_spr_decode u_dec (
    .addr_i (spr_addr_i),
    .win_o  (win),
    .idx_o  (spr_idx)
  );

  itlb_entry_array u_arr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_match_i (we_m),
    .we_xlate_i (we_x),
    .widx_i     (spr_idx),
    .wdata_i    (spr_wdata_i),
    .ridx_a_i   (lkp_idx),
    .rent_a_o   (lkp_ent),
    .ridx_b_i   (spr_idx),
    .rent_b_o   (spr_ent)
  );

  itlb_lookup_stage u_lkp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (lkp_en_i),
    .vaddr_i (lkp_vaddr_i),
    .rent_i  (lkp_ent),
    .hit_o   (hit_o),
    .ppn_o   (ppn_o),
    .uxe_o   (uxe_o),
    .sxe_o   (sxe_o),
    .ci_o    (ci_o)
  );

  itlb_spr_read u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (rd),
    .win_i   (win),
    .rent_i  (spr_ent),
    .rdata_o (spr_rdata_o)
  );
endmodule

// File: rtl/itlb_dm_chk.sv
`timescale 1ns/1ps
module itlb_dm_chk
  import itlb_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lkp_en_i,
  input logic              hit_o,
  input logic [PPN_W-1:0]  ppn_o,
  input logic              uxe_o,
  input logic              sxe_o,
  input logic              ci_o,
  input logic              spr_cs_i,
  input logic              spr_we_i,
  input logic [SPR_AW-1:0] spr_addr_i,
  input logic [DATA_W-1:0] spr_rdata_o
);
  logic rd_m, rd_x, rd_o;

  assign rd_m = spr_cs_i && !spr_we_i &&
                (spr_addr_i[SPR_AW-1:IDX_W] == MATCH_BASE[SPR_AW-1:IDX_W]);
  assign rd_x = spr_cs_i && !spr_we_i &&
                (spr_addr_i[SPR_AW-1:IDX_W] == XLATE_BASE[SPR_AW-1:IDX_W]);
  assign rd_o = spr_cs_i && !spr_we_i && !rd_m && !rd_x;

  // R5
  lkp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(lkp_en_i) |-> $stable({hit_o, ppn_o, uxe_o, sxe_o, ci_o}));

  // R2
  hit_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hit_o) |-> $past(lkp_en_i));

  // R9
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(spr_cs_i && !spr_we_i) |-> $stable(spr_rdata_o));

  // R8
  rdata_outside_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_o) |-> (spr_rdata_o == '0));

  // R6
  match_unused_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_m) |-> (spr_rdata_o[TAG_LSB-1:1] == '0));

  // R7
  xlate_unused_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_x) |-> (spr_rdata_o[PAGE_W-1:UXE_POS+1] == '0 &&
                     spr_rdata_o[SXE_POS-1:CI_POS+1] == '0 &&
                     spr_rdata_o[VALID_POS] == 1'b0));
endmodule

bind itlb_dm itlb_dm_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lkp_en_i    (lkp_en_i),
  .hit_o       (hit_o),
  .ppn_o       (ppn_o),
  .uxe_o       (uxe_o),
  .sxe_o       (sxe_o),
  .ci_o        (ci_o),
  .spr_cs_i    (spr_cs_i),
  .spr_we_i    (spr_we_i),
  .spr_addr_i  (spr_addr_i),
  .spr_rdata_o (spr_rdata_o)
);

// File: tb/sim_itlb_dm.sv
`timescale 1ns/1ps
module sim_itlb_dm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lkp_en = 1'b0;
  logic [31:0] lkp_va = '0;
  logic        hit, uxe, sxe, ci;
  logic [18:0] ppn;
  logic        cs = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0, rdata;

  int checks = 0;
  int errors = 0;

  // model
  logic        m_valid [64];
  logic [12:0] m_tag   [64];
  logic [18:0] m_ppn   [64];
  logic        m_uxe   [64], m_sxe [64], m_ci [64];

  always #2.5 clk = ~clk;

  itlb_dm u0 (
    .clk_i(clk), .rst_ni(rst_n), .lkp_en_i(lkp_en), .lkp_vaddr_i(lkp_va),
    .hit_o(hit), .ppn_o(ppn), .uxe_o(uxe), .sxe_o(sxe), .ci_o(ci),
    .spr_cs_i(cs), .spr_we_i(we), .spr_addr_i(addr), .spr_wdata_i(wdata),
    .spr_rdata_o(rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_match(input int i);
    logic [31:0] w = '0;
    w[0] = m_valid[i];
    w[31:19] = m_tag[i];
    return w;
  endfunction

  function automatic logic [31:0] exp_xlate(input int i);
    logic [31:0] w = '0;
    w[31:13] = m_ppn[i];
    w[7] = m_uxe[i];
    w[6] = m_sxe[i];
    w[1] = m_ci[i];
    return w;
  endfunction

  function automatic logic [31:0] exp_read(input logic [15:0] a);
    if (a[15:6] == 10'h048) return exp_match(int'(a[5:0]));
    if (a[15:6] == 10'h04C) return exp_xlate(int'(a[5:0]));
    return 32'h0;
  endfunction

  function automatic void model_write(input logic [15:0] a, input logic [31:0] d);
    int i = int'(a[5:0]);
    if (a[15:6] == 10'h048) begin
      m_valid[i] = d[0];
      m_tag[i]   = d[31:19];
    end else if (a[15:6] == 10'h04C) begin
      m_ppn[i] = d[31:13];
      m_uxe[i] = d[7];
      m_sxe[i] = d[6];
      m_ci[i]  = d[1];
    end
  endfunction

  task automatic spr_wr(input logic [15:0] a, input logic [31:0] d);
    cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
    model_write(a, d);
  endtask

  task automatic spr_rd(input logic [15:0] a, input string req);
    logic [31:0] e;
    cs = 1'b1; we = 1'b0; addr = a;
    e = exp_read(a);
    @(negedge clk);
    cs = 1'b0;
    chk(rdata == e, req, rdata, e);
  endtask

  task automatic lookup(input logic [31:0] va, input string req);
    int i = int'(va[18:13]);
    logic eh;
    lkp_en = 1'b1; lkp_va = va;
    eh = m_valid[i] && (m_tag[i] == va[31:19]);
    @(negedge clk);
    lkp_en = 1'b0;
    chk(hit == eh, {req, " hit"}, 32'(hit), 32'(eh));
    chk({ppn, uxe, sxe, ci} == {m_ppn[i], m_uxe[i], m_sxe[i], m_ci[i]}, {req, " fields"},
        32'({ppn, uxe, sxe, ci}), 32'({m_ppn[i], m_uxe[i], m_sxe[i], m_ci[i]}));
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] hold;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) begin
      m_valid[i] = 0; m_tag[i] = '0; m_ppn[i] = '0; m_uxe[i] = 0; m_sxe[i] = 0; m_ci[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(hit == 0 && ppn == 0 && rdata == 0, "R1 reset outputs", 32'({hit, ppn}), 0);
    lookup(32'h0000_0000, "R1 lookup after reset");
    lookup(32'hFFFF_FFFF, "R1 lookup after reset");
    spr_rd(16'h1205, "R1 match reset");

    // R6/R7 layout
    spr_wr(16'h1203, 32'hABCD_FFFF);
    spr_rd(16'h1203, "R6 match readback");
    spr_wr(16'h1303, 32'hFFFF_FFFF);
    spr_rd(16'h1303, "R7 translate readback");

    // R2/R3/R4 hit and offset independence
    lookup({13'h1579, 6'd3, 13'h1FFF}, "R2 hit with offset");
    lookup({13'h1579, 6'd3, 13'h0000}, "R2 hit zero offset");
    lookup({13'h1578, 6'd3, 13'h0000}, "R3 tag mismatch");
    spr_wr(16'h1203, 32'hABC8_0000);
    lookup({13'h1579, 6'd3, 13'h0000}, "R3 invalid entry");

    // R5 hold
    spr_wr(16'h1207, {13'h0042, 18'h0, 1'b1});
    spr_wr(16'h1307, 32'h1234_E0C2);
    lookup({13'h0042, 6'd7, 13'h0100}, "R5 setup");
    hold = 32'({hit, ppn, uxe, sxe, ci});
    lkp_va = 32'h0000_0000;
    @(negedge clk);
    chk(32'({hit, ppn, uxe, sxe, ci}) == hold, "R5 hold", 32'({hit, ppn, uxe, sxe, ci}), hold);

    // R8 writes ignored outside windows / without strobe
    spr_wr(16'h1247, 32'h0);
    spr_wr(16'h1347, 32'h0);
    cs = 1'b0; we = 1'b1; addr = 16'h1207; wdata = 32'h0;
    @(negedge clk);
    we = 1'b0;
    lookup({13'h0042, 6'd7, 13'h0000}, "R8 ignored writes");
    spr_rd(16'h1240, "R8 outside read");
    spr_rd(16'h0000, "R8 outside read");

    // R9 hold of read data
    spr_rd(16'h1307, "R9 read");
    hold = rdata;
    addr = 16'h1200;
    @(negedge clk);
    chk(rdata == hold, "R9 hold", rdata, hold);

    // R10 same-edge lookup and write
    lkp_en = 1'b1; lkp_va = {13'h0042, 6'd7, 13'h0000};
    cs = 1'b1; we = 1'b1; addr = 16'h1207; wdata = 32'h0;
    @(negedge clk);
    lkp_en = 1'b0; cs = 1'b0; we = 1'b0;
    chk(hit == 1'b1, "R10 old contents", 32'(hit), 1);
    model_write(16'h1207, 32'h0);
    lookup({13'h0042, 6'd7, 13'h0000}, "R10 after write");

    // random traffic
    for (int n = 0; n < 600; n++) begin
      int op = int'($urandom % 5);
      logic [5:0] ix = 6'($urandom);
      case (op)
        0: spr_wr({10'h048, ix}, $urandom);
        1: spr_wr({10'h04C, ix}, $urandom);
        2: spr_rd({($urandom % 2) ? 10'h048 : 10'h04C, ix}, "R6 R7 random read");
        3: spr_rd({10'(($urandom % 2) ? 10'h049 : 10'(($urandom))), ix}, "R8 random read");
        default: lookup({($urandom % 3 != 0) ? m_tag[ix] : 13'($urandom), ix, 13'($urandom)},
                        "R2 R3 R4 random lookup");
      endcase
    end

    finish_run();
  end
endmodule